// File: doc/BRIEF.md
# Store Access Legality Checker

This block sits between instruction decode and the data memory port and decides, for every store-class operation, whether it may touch memory at all. It accepts one operation at a time (plain byte, halfword, word and doubleword stores, their alternate-space versions, single and double floating-point stores, the FP status store, the FP queue store, and the atomic swap). For each one it either raises a single trap code or issues a memory request carrying a size code, an address-space number and a source register index. It then finishes the operation with a one-cycle completion pulse.

Legality is settled in the cycle the operation is accepted, as one prioritised decision. The memory side uses a request/acknowledge pair. An error flag on the acknowledge becomes the data-access trap. The swap runs as a read followed by a write, and it updates its destination register only when both accesses succeed. A completion without a trap asserts `pc_advance`. A trapped store never asserts it, so the store can be restarted.

Top module: `store_gate`

## Requirements
- R1: Operation kinds on `op_kind` are 0 byte, 1 halfword, 2 word, 3 double, 4 alt byte, 5 alt halfword, 6 alt word, 7 alt double, 8 FP single, 9 FP double, 10 FP status, 11 FP queue, 12 swap, 13 alt swap. Kinds 14 and 15 complete with trap code 2 and issue no access.
- R2: `mem_size` is 0 for a byte, 1 for a halfword, 2 for word, FP single, FP status and swap, and 3 for all doubleword kinds.
- R3: A halfword with `eff_addr[0]` set, a word-size access with `eff_addr[1:0]` nonzero, or a doubleword with `eff_addr[2:0]` nonzero completes with trap code 4 (unaligned) and no access. Byte stores are never misaligned.
- R4: An alternate-space kind with `sup_mode` low completes with trap code 1 (privileged).
- R5: An alternate-space kind in supervisor mode with `imm_sel` high completes with trap code 2 (unimplemented). Otherwise `mem_space` equals `asi_bits`.
- R6: Non-alternate kinds use space `SUPER_SPACE` (default 0x0B) when `sup_mode` is high and `USER_SPACE` (default 0x0A) otherwise.
- R7: FP kinds (8 to 11) complete with trap code 3 (FP disabled) unless both `fp_en` and `fpu_here` are high.
- R8: When several checks fail, the code reported follows the order privilege, immediate bit, FP enable, alignment. Only one code is reported.
- R9: Every doubleword access presents `mem_reg` with bit 0 cleared.
- R10: An error on a write acknowledge completes the store with trap code 5 (data access).
- R11: A swap reads first and then writes. A read error completes with trap code 5 and issues no write. `rd_we` pulses with `rd_wdata` equal to the read data only when the write succeeds.
- R12: An FP queue store that passes its traps but sees `fq_nonempty` low completes with `fq_seq_err` high, no access, no trap and `pc_advance` high. On success it pulses `fq_drain`.
- R13: `pc_advance` is high on completion exactly when the trap code is 0. It is never high when `done` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_valid | input | 1 | Accept an operation (only while not busy) |
| op_kind | input | 4 | Operation kind |
| eff_addr | input | AW | Effective address |
| rd_idx | input | 5 | Source/destination register field |
| sup_mode | input | 1 | Supervisor status bit |
| fp_en | input | 1 | FP-enable status bit |
| fpu_here | input | 1 | FPU present |
| imm_sel | input | 1 | Instruction immediate bit |
| asi_bits | input | 8 | Address-space field of the instruction |
| fq_nonempty | input | 1 | FP queue holds an entry |
| busy | output | 1 | Operation in progress |
| mem_req | output | 1 | Memory request, held until acknowledged |
| mem_we | output | 1 | 1 write, 0 read |
| mem_size | output | 2 | Access size code |
| mem_addr | output | AW | Access address |
| mem_space | output | 8 | Address-space number |
| mem_reg | output | 5 | Register index supplying store data |
| mem_ack | input | 1 | Memory acknowledge |
| mem_err | input | 1 | Error qualifier of the acknowledge |
| mem_rdata | input | 32 | Read data for swap |
| done | output | 1 | One-cycle completion |
| trap_code | output | 3 | Trap raised, valid with `done` |
| pc_advance | output | 1 | PC pair may advance |
| fq_seq_err | output | 1 | FP queue sequence error |
| fq_drain | output | 1 | Clear queue-not-empty, FPU back to execute |
| rd_we | output | 1 | Swap destination write |
| rd_wdata | output | 32 | Swap destination data |

## Verification
The interesting collisions are several legality checks failing on one operation, and a memory error landing on one half of a swap. The bench presents user-mode alternate stores that also carry the immediate bit and a bad address. It also presents disabled FP stores that are misaligned or that target an empty queue. It then judges that only the highest-priority code appears and that no access is issued. For the swap, the memory model injects an error on the read or on the write. The scoreboard compares the count of reads and writes seen, the trap code, and the presence and value of the register write-back.

// File: rtl/store_gate.sv
module store_gate #(
  parameter int AW = 32,
  parameter logic [7:0] USER_SPACE = 8'h0A,
  parameter logic [7:0] SUPER_SPACE = 8'h0B
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          op_valid,
  input  logic [3:0]    op_kind,
  input  logic [AW-1:0] eff_addr,
  input  logic [4:0]    rd_idx,
  input  logic          sup_mode,
  input  logic          fp_en,
  input  logic          fpu_here,
  input  logic          imm_sel,
  input  logic [7:0]    asi_bits,
  input  logic          fq_nonempty,
  output logic          busy,
  output logic          mem_req,
  output logic          mem_we,
  output logic [1:0]    mem_size,
  output logic [AW-1:0] mem_addr,
  output logic [7:0]    mem_space,
  output logic [4:0]    mem_reg,
  input  logic          mem_ack,
  input  logic          mem_err,
  input  logic [31:0]   mem_rdata,
  output logic          done,
  output logic [2:0]    trap_code,
  output logic          pc_advance,
  output logic          fq_seq_err,
  output logic          fq_drain,
  output logic          rd_we,
  output logic [31:0]   rd_wdata
);
  localparam logic [2:0] T_NONE = 3'd0, T_PRIV = 3'd1, T_UNIMP = 3'd2,
                         T_FPDIS = 3'd3, T_ALIGN = 3'd4, T_DACC = 3'd5;

  typedef enum logic [1:0] {S_IDLE, S_READ, S_WRITE, S_FIN} st_t;
  st_t st;

  logic is_alt, is_fp, is_swap, is_fq, known;
  logic [1:0] sz;
  logic misal;
  logic [2:0] chk;

  assign is_alt  = (op_kind >= 4'd4 && op_kind <= 4'd7) || op_kind == 4'd13;
  assign is_fp   = op_kind >= 4'd8 && op_kind <= 4'd11;
  assign is_swap = op_kind == 4'd12 || op_kind == 4'd13;
  assign is_fq   = op_kind == 4'd11;
  assign known   = op_kind <= 4'd13;

  always_comb begin
    case (op_kind)
      4'd0, 4'd4:                     sz = 2'd0;
      4'd1, 4'd5:                     sz = 2'd1;
      4'd3, 4'd7, 4'd9, 4'd11:        sz = 2'd3;
      default:                        sz = 2'd2;
    endcase
  end

  always_comb begin
    case (sz)
      2'd1:    misal = eff_addr[0];
      2'd2:    misal = |eff_addr[1:0];
      2'd3:    misal = |eff_addr[2:0];
      default: misal = 1'b0;
    endcase
  end

  always_comb begin
    if (!known)                           chk = T_UNIMP;
    else if (is_alt && !sup_mode)         chk = T_PRIV;
    else if (is_alt && imm_sel)           chk = T_UNIMP;
    else if (is_fp && !(fp_en && fpu_here)) chk = T_FPDIS;
    else if (misal)                       chk = T_ALIGN;
    else                                  chk = T_NONE;
  end

  logic swap_q, fq_q, seq_q, drain_q, rdw_q;
  logic [2:0] trap_q;
  logic [31:0] rdata_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE;
      mem_size <= '0;
      mem_addr <= '0;
      mem_space <= '0;
      mem_reg <= '0;
      swap_q <= 1'b0;
      fq_q <= 1'b0;
      seq_q <= 1'b0;
      drain_q <= 1'b0;
      rdw_q <= 1'b0;
      trap_q <= T_NONE;
      rdata_q <= '0;
    end else begin
      case (st)
        S_IDLE: if (op_valid) begin
          mem_size  <= sz;
          mem_addr  <= eff_addr;
          mem_space <= is_alt ? asi_bits : (sup_mode ? SUPER_SPACE : USER_SPACE);
          mem_reg   <= (sz == 2'd3) ? {rd_idx[4:1], 1'b0} : rd_idx;
          swap_q    <= is_swap;
          fq_q      <= is_fq;
          trap_q    <= chk;
          seq_q     <= (chk == T_NONE) && is_fq && !fq_nonempty;
          drain_q   <= 1'b0;
          rdw_q     <= 1'b0;
          if (chk != T_NONE || (is_fq && !fq_nonempty)) st <= S_FIN;
          else if (is_swap)                             st <= S_READ;
          else                                          st <= S_WRITE;
        end
        S_READ: if (mem_ack) begin
          if (mem_err) begin
            trap_q <= T_DACC;
            st <= S_FIN;
          end else begin
            rdata_q <= mem_rdata;
            st <= S_WRITE;
          end
        end
        S_WRITE: if (mem_ack) begin
          if (mem_err) trap_q <= T_DACC;
          else begin
            rdw_q   <= swap_q;
            drain_q <= fq_q;
          end
          st <= S_FIN;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assign busy       = st != S_IDLE;
  assign mem_req    = st == S_READ || st == S_WRITE;
  assign mem_we     = st == S_WRITE;
  assign done       = st == S_FIN;
  assign trap_code  = trap_q;
  assign pc_advance = done && trap_q == T_NONE;
  assign fq_seq_err = done && seq_q;
  assign fq_drain   = done && drain_q;
  assign rd_we      = done && rdw_q;
  assign rd_wdata   = rdata_q;
endmodule

module store_gate_chk #(
  parameter int AW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          mem_req,
  input logic          mem_we,
  input logic [1:0]    mem_size,
  input logic [AW-1:0] mem_addr,
  input logic [4:0]    mem_reg,
  input logic          mem_ack,
  input logic          mem_err,
  input logic          done,
  input logic [2:0]    trap_code,
  input logic          pc_advance,
  input logic          rd_we
);
  assert_aligned_req_R3: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> ((mem_size == 2'd1) ? !mem_addr[0] :
                 (mem_size == 2'd2) ? (mem_addr[1:0] == 2'b00) :
                 (mem_size == 2'd3) ? (mem_addr[2:0] == 3'b000) : 1'b1));

  assert_even_pair_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_size == 2'd3) |-> !mem_reg[0]);

  assert_no_write_after_bad_read_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_we && mem_ack && mem_err) |=> (!mem_req && done && trap_code == 3'd5));

  assert_writeback_clean_R11: assert property (@(posedge clk) disable iff (!rst_n)
    rd_we |-> (done && trap_code == 3'd0));

  assert_restartable_R13: assert property (@(posedge clk) disable iff (!rst_n)
    pc_advance |-> (done && trap_code == 3'd0));

  assert_write_err_traps_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_we && mem_ack && mem_err) |=> (done && !pc_advance));
endmodule

bind store_gate store_gate_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .mem_req(mem_req), .mem_we(mem_we),
  .mem_size(mem_size), .mem_addr(mem_addr), .mem_reg(mem_reg),
  .mem_ack(mem_ack), .mem_err(mem_err), .done(done),
  .trap_code(trap_code), .pc_advance(pc_advance), .rd_we(rd_we)
);

// File: tb/store_gate_tb.sv
module store_gate_tb;
  localparam int CLK_NS = 10;
  localparam int AW = 32;

  logic clk = 1'b0, rst_n = 1'b0;
  logic op_valid = 1'b0;
  logic [3:0] op_kind = '0;
  logic [AW-1:0] eff_addr = '0;
  logic [4:0] rd_idx = '0;
  logic sup_mode = 0, fp_en = 0, fpu_here = 0, imm_sel = 0, fq_nonempty = 0;
  logic [7:0] asi_bits = '0;
  logic busy, mem_req, mem_we, done, pc_advance, fq_seq_err, fq_drain, rd_we;
  logic [1:0] mem_size;
  logic [AW-1:0] mem_addr;
  logic [7:0] mem_space;
  logic [4:0] mem_reg;
  logic mem_ack = 0, mem_err = 0;
  logic [31:0] mem_rdata = '0;
  logic [2:0] trap_code;
  logic [31:0] rd_wdata;

  always #(CLK_NS/2) clk = ~clk;

  store_gate #(.AW(AW)) u_dut (.*);

  typedef struct {
    string tag;
    logic [2:0] trap;
    logic pcadv, seq, drain, rdwe;
    logic [31:0] rdata;
    int nrd, nwr;
    logic [1:0] size;
    logic [7:0] space;
    logic [4:0] rg;
  } exp_t;

  exp_t q[$];
  int n_chk = 0, n_bad = 0;
  int nrd = 0, nwr = 0;
  logic [1:0] w_size; logic [7:0] w_space; logic [4:0] w_reg;
  logic err_r = 0, err_w = 0;

  task automatic cmp(input string tag, input string what, input longint act, input longint exp);
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  // memory model
  initial forever begin
    @(negedge clk);
    if (mem_req) begin
      if (mem_we) begin nwr++; w_size = mem_size; w_space = mem_space; w_reg = mem_reg; end
      else nrd++;
      mem_rdata = 32'hC0DE_0000 ^ mem_addr;
      @(negedge clk);
      mem_ack = 1'b1;
      mem_err = mem_we ? err_w : err_r;
      @(negedge clk);
      mem_ack = 1'b0;
      mem_err = 1'b0;
    end
  end

  // monitor
  initial forever begin
    @(negedge clk);
    if (rst_n && done) begin
      exp_t e;
      n_chk++;
      if (q.size() == 0) begin
        n_bad++;
        $display("FAIL R13 unexpected done: actual 1 expected 0");
      end else begin
        e = q.pop_front();
        cmp(e.tag, "trap", trap_code, e.trap);
        cmp(e.tag, "pc_advance", pc_advance, e.pcadv);
        cmp(e.tag, "seq_err", fq_seq_err, e.seq);
        cmp(e.tag, "drain", fq_drain, e.drain);
        cmp(e.tag, "rd_we", rd_we, e.rdwe);
        if (e.rdwe) cmp(e.tag, "rd_wdata", rd_wdata, e.rdata);
        cmp(e.tag, "reads", nrd, e.nrd);
        cmp(e.tag, "writes", nwr, e.nwr);
        if (e.nwr == 1) begin
          cmp(e.tag, "size", w_size, e.size);
          cmp(e.tag, "space", w_space, e.space);
          cmp(e.tag, "reg", w_reg, e.rg);
        end
      end
    end
  end

  task automatic go(input string tag, input logic [3:0] k, input logic [31:0] a, input logic [4:0] r,
                    input logic sup, input logic fe, input logic fp, input logic im,
                    input logic [7:0] asi, input logic qn, input logic er, input logic ew,
                    input logic [2:0] etrap, input logic eseq, input int enrd, input int enwr,
                    input logic [1:0] esz, input logic [7:0] esp, input logic [4:0] erg);
    exp_t e;
    @(negedge clk);
    while (busy) @(negedge clk);
    nrd = 0; nwr = 0; err_r = er; err_w = ew;
    e.tag = tag; e.trap = etrap; e.pcadv = (etrap == 0); e.seq = eseq;
    e.drain = (k == 4'd11) && etrap == 0 && !eseq;
    e.rdwe = (k == 4'd12 || k == 4'd13) && etrap == 0;
    e.rdata = 32'hC0DE_0000 ^ a;
    e.nrd = enrd; e.nwr = enwr; e.size = esz; e.space = esp; e.rg = erg;
    q.push_back(e);
    op_kind = k; eff_addr = a; rd_idx = r; sup_mode = sup; fp_en = fe; fpu_here = fp;
    imm_sel = im; asi_bits = asi; fq_nonempty = qn; op_valid = 1'b1;
    @(negedge clk);
    op_valid = 1'b0;
    while (q.size() != 0) @(negedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual hang expected completion");
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    n_chk++;
    cmp("R13 reset", "done", done, 0);
    cmp("R13 reset", "mem_req", mem_req, 0);
    cmp("R13 reset", "busy", busy, 0);
    //   tag        kind addr   rd sup fe fp im asi  qn er ew trap seq rd wr sz sp    reg
    go("R2 byte",   0, 32'h13, 3, 0, 0, 0, 0, 8'h0, 0, 0, 0, 0, 0, 0, 1, 0, 8'h0A, 3);
    go("R3 half",   1, 32'h11, 3, 0, 0, 0, 0, 8'h0, 0, 0, 0, 4, 0, 0, 0, 0, 8'h0, 0);
    go("R2 half",   1, 32'h12, 6, 0, 0, 0, 0, 8'h0, 0, 0, 0, 0, 0, 0, 1, 1, 8'h0A, 6);
    go("R3 word",   2, 32'h22, 1, 1, 0, 0, 0, 8'h0, 0, 0, 0, 4, 0, 0, 0, 0, 8'h0, 0);
    go("R6 word",   2, 32'h24, 1, 1, 0, 0, 0, 8'h0, 0, 0, 0, 0, 0, 0, 1, 2, 8'h0B, 1);
    go("R3 dbl",    3, 32'h44, 5, 1, 0, 0, 0, 8'h0, 0, 0, 0, 4, 0, 0, 0, 0, 8'h0, 0);
    go("R9 dbl",    3, 32'h48, 5, 1, 0, 0, 0, 8'h0, 0, 0, 0, 0, 0, 0, 1, 3, 8'h0B, 4);
    go("R4 alt",    6, 32'h40, 2, 0, 0, 0, 0, 8'h5A,0, 0, 0, 1, 0, 0, 0, 0, 8'h0, 0);
    go("R8 priv",   5, 32'h41, 2, 0, 0, 0, 1, 8'h5A,0, 0, 0, 1, 0, 0, 0, 0, 8'h0, 0);
    go("R5 imm",    7, 32'h44, 2, 1, 0, 0, 1, 8'h5A,0, 0, 0, 2, 0, 0, 0, 0, 8'h0, 0);
    go("R5 asi",    4, 32'h43, 9, 1, 0, 0, 0, 8'h5A,0, 0, 0, 0, 0, 0, 1, 0, 8'h5A, 9);
    go("R9 alt dbl",7, 32'h50, 7, 1, 0, 0, 0, 8'h21,0, 0, 0, 0, 0, 0, 1, 3, 8'h21, 6);
    go("R7 fp off", 8, 32'h42, 2, 1, 0, 1, 0, 8'h0, 0, 0, 0, 3, 0, 0, 0, 0, 8'h0, 0);
    go("R7 no fpu", 8, 32'h40, 2, 1, 1, 0, 0, 8'h0, 0, 0, 0, 3, 0, 0, 0, 0, 8'h0, 0);
    go("R7 fp ok",  8, 32'h40, 2, 0, 1, 1, 0, 8'h0, 0, 0, 0, 0, 0, 0, 1, 2, 8'h0A, 2);
    go("R3 fp dbl", 9, 32'h44, 2, 1, 1, 1, 0, 8'h0, 0, 0, 0, 4, 0, 0, 0, 0, 8'h0, 0);
    go("R2 fsr",   10, 32'h60, 0, 1, 1, 1, 0, 8'h0, 0, 0, 0, 0, 0, 0, 1, 2, 8'h0B, 0);
    go("R12 seq",  11, 32'h80, 0, 1, 1, 1, 0, 8'h0, 0, 0, 0, 0, 1, 0, 0, 0, 8'h0, 0);
    go("R8 fq",    11, 32'h80, 0, 1, 0, 1, 0, 8'h0, 0, 0, 0, 3, 0, 0, 0, 0, 8'h0, 0);
    go("R12 drain",11, 32'h88, 0, 1, 1, 1, 0, 8'h0, 1, 0, 0, 0, 0, 0, 1, 3, 8'h0B, 0);
    go("R10 werr",  2, 32'h90, 4, 1, 0, 0, 0, 8'h0, 0, 0, 1, 5, 0, 0, 1, 2, 8'h0B, 4);
    go("R11 swap", 12, 32'hA4, 8, 0, 0, 0, 0, 8'h0, 0, 0, 0, 0, 0, 1, 1, 2, 8'h0A, 8);
    go("R11 rerr", 12, 32'hA8, 8, 0, 0, 0, 0, 8'h0, 0, 1, 0, 5, 0, 1, 0, 0, 8'h0, 0);
    go("R11 werr", 13, 32'hAC, 8, 1, 0, 0, 0, 8'h33,0, 0, 1, 5, 0, 1, 1, 2, 8'h33, 8);
    go("R1 bad",   15, 32'h0,  0, 1, 1, 1, 0, 8'h0, 1, 0, 0, 2, 0, 0, 0, 0, 8'h0, 0);
    repeat (2) @(negedge clk);
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule